// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block turns the interrupt sources of a 16550-style serial port into one identification code and one interrupt request line. The inputs are the enable register, the line error and break status, data-ready, the receive queue fill level with its trigger selection, a FIFO-mode flag, a character-timeout pending flag, the transmit-holding-empty status and events, and the modem-status delta bits. The output is the value software reads from the identification register.

The block keeps three pieces of state of its own: the 4-bit interrupt enable register, the transmitter-empty pending flag and the break flag. Register access strobes from the bus decoder change these flags. Reading the identification register drops a pending transmitter-empty source. Writing the enable register re-arms that source while the holding register is empty. Reading the line status register clears a latched break. Data storage, the baud generator and the serializers sit elsewhere and reach this block only as plain status inputs.

The code and the request line are combinational in the inputs and the stored flags. A change in a status input therefore shows up in the same cycle. A register strobe takes effect after the next clock edge.

Top module: `uart_irq_ident`

## Requirements
- R1: When several sources are active, the code reports the highest one. The order, highest first, is: line status (0x6), character timeout (0xC), receive data (0x4), transmitter empty (0x2), modem status (0x0). The code is in iir_o[3:0].
- R2: With no active source, iir_o[3:0] is 0x1 and irq_o is low. After reset, ier_o, thr_pend_o and brk_o are 0 and iir_o is 0x01.
- R3: The line-status source is active when ier_o[2] is set and at least one of lsr_err_i[2:0] (overrun, parity, framing) or brk_o is set.
- R4: The receive-data source needs ier_o[0] and data_ready_i. When fifo_en_i is set, it also needs rx_count_i to be at least the trigger level. trig_sel_i selects the level: 0→1, 1→4, 2→8, 3→14.
- R5: char_to_i raises the timeout source (0xC) whatever the value of ier_o.
- R6: The transmitter-empty source is active when ier_o[1] and thr_pend_o are set. thre_set_i sets the flag. A read strobe of the identification register (iir_re_i) clears it, and so does a write to the holding register (thr_we_i). When a set and a clear arrive in the same cycle, the set wins.
- R7: An ier_we_i strobe stores ier_wdata_i[3:0] into ier_o and discards bits 7:4. If thre_i is high during that write, thr_pend_o is set.
- R8: The modem-status source is active when ier_o[3] is set and any bit of msr_delta_i is set.
- R9: iir_o[7:6] is 2'b11 while fifo_en_i is set and 2'b00 otherwise. iir_o[5:4] is always 0.
- R10: brk_det_i sets brk_o. An lsr_re_i strobe while brk_o is set clears it. When both arrive in the same cycle, brk_det_i wins.
- R11: irq_o is high exactly when iir_o[0] is 0. It follows a status input in the same cycle.
- R12: If receive data is enabled and ready but held back by the trigger level, the next lower active source is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ier_we_i | input | 1 | Enable register write strobe |
| ier_wdata_i | input | 8 | Enable register write data |
| iir_re_i | input | 1 | Identification register read strobe |
| lsr_re_i | input | 1 | Line status register read strobe |
| thr_we_i | input | 1 | Holding register write strobe |
| thre_i | input | 1 | Holding register empty status |
| thre_set_i | input | 1 | Holding register became empty (event) |
| lsr_err_i | input | 3 | Overrun, parity, framing error status |
| brk_det_i | input | 1 | Break detected (event) |
| data_ready_i | input | 1 | Receive data ready |
| fifo_en_i | input | 1 | FIFO mode enabled |
| rx_count_i | input | CNT_W | Receive queue fill level |
| trig_sel_i | input | 2 | Receive trigger level select |
| char_to_i | input | 1 | Character timeout pending |
| msr_delta_i | input | 4 | Modem status delta bits |
| ier_o | output | 4 | Stored enable register |
| thr_pend_o | output | 1 | Transmitter-empty pending flag |
| brk_o | output | 1 | Latched break flag |
| iir_o | output | 8 | Identification register value |
| irq_o | output | 1 | Interrupt request |

## Verification
A status input reaches iir_o and irq_o in the same cycle. The bench therefore sets these inputs just after a falling edge and samples 1 ns later, before any rising edge. A strobe or event (enable write, identification or line-status read, holding write, thre_set_i, brk_det_i) acts at the next rising edge. The bench raises it at a falling edge, drops it at the next falling edge, and samples the flags and the code after that. Each table vector first clears the pending flag and loads the enable register. It then pulses thre_set_i if the vector needs it, so the stored state is known one full cycle before the code is checked.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  typedef enum logic [3:0] {
    IID_MSR  = 4'h0,
    IID_NONE = 4'h1,
    IID_THR  = 4'h2,
    IID_RXD  = 4'h4,
    IID_RLS  = 4'h6,
    IID_CTO  = 4'hC
  } iid_e;

  localparam int unsigned NUM_SRC = 5;

  // enable register bit positions
  localparam int unsigned IE_RXD = 0;
  localparam int unsigned IE_THR = 1;
  localparam int unsigned IE_RLS = 2;
  localparam int unsigned IE_MSR = 3;
endpackage

// File: rtl/uart_irq_trig.sv
module uart_irq_trig #(
  parameter int unsigned CNT_W = 5,
  parameter int unsigned LVL0  = 1,
  parameter int unsigned LVL1  = 4,
  parameter int unsigned LVL2  = 8,
  parameter int unsigned LVL3  = 14
) (
  input  logic [1:0]       sel_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             reached_o
);
  logic [CNT_W-1:0] lvl;

  always_comb begin
    unique case (sel_i)
      2'd0:    lvl = CNT_W'(LVL0);
      2'd1:    lvl = CNT_W'(LVL1);
      2'd2:    lvl = CNT_W'(LVL2);
      default: lvl = CNT_W'(LVL3);
    endcase
  end

  assign reached_o = (count_i >= lvl);
endmodule

// File: rtl/uart_irq_regs.sv
module uart_irq_regs (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ier_we_i,
  input  logic [7:0] ier_wdata_i,
  input  logic       iir_re_i,
  input  logic       lsr_re_i,
  input  logic       thr_we_i,
  input  logic       thre_i,
  input  logic       thre_set_i,
  input  logic       brk_det_i,
  output logic [3:0] ier_o,
  output logic       thr_pend_o,
  output logic       brk_o
);
  logic thp_set, thp_clr, brk_clr;

  assign thp_set = thre_set_i | (ier_we_i & thre_i);
  assign thp_clr = iir_re_i | thr_we_i;
  assign brk_clr = lsr_re_i & brk_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ier_o      <= '0;
      thr_pend_o <= 1'b0;
      brk_o      <= 1'b0;
    end else begin
      if (ier_we_i) ier_o <= ier_wdata_i[3:0];
      // set beats clear
      if (thp_set)      thr_pend_o <= 1'b1;
      else if (thp_clr) thr_pend_o <= 1'b0;
      if (brk_det_i)    brk_o <= 1'b1;
      else if (brk_clr) brk_o <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic [NUM_SRC-1:0] req_i,  // index 0 = highest
  output logic [3:0]         code_o
);
  localparam logic [3:0] SRC_CODE [NUM_SRC] = '{IID_RLS, IID_CTO, IID_RXD, IID_THR, IID_MSR};

  always_comb begin
    code_o = IID_NONE;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) code_o = SRC_CODE[i];
    end
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned CNT_W      = $clog2(FIFO_DEPTH + 1),
  parameter int unsigned LVL0       = 1,
  parameter int unsigned LVL1       = 4,
  parameter int unsigned LVL2       = 8,
  parameter int unsigned LVL3       = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ier_we_i,
  input  logic [7:0]       ier_wdata_i,
  input  logic             iir_re_i,
  input  logic             lsr_re_i,
  input  logic             thr_we_i,
  input  logic             thre_i,
  input  logic             thre_set_i,
  input  logic [2:0]       lsr_err_i,
  input  logic             brk_det_i,
  input  logic             data_ready_i,
  input  logic             fifo_en_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic [1:0]       trig_sel_i,
  input  logic             char_to_i,
  input  logic [3:0]       msr_delta_i,
  output logic [3:0]       ier_o,
  output logic             thr_pend_o,
  output logic             brk_o,
  output logic [7:0]       iir_o,
  output logic             irq_o
);
  logic             lvl_ok;
  logic [NUM_SRC-1:0] req;
  logic [3:0]       code;

  uart_irq_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ier_we_i    (ier_we_i),
    .ier_wdata_i (ier_wdata_i),
    .iir_re_i    (iir_re_i),
    .lsr_re_i    (lsr_re_i),
    .thr_we_i    (thr_we_i),
    .thre_i      (thre_i),
    .thre_set_i  (thre_set_i),
    .brk_det_i   (brk_det_i),
    .ier_o       (ier_o),
    .thr_pend_o  (thr_pend_o),
    .brk_o       (brk_o)
  );

  uart_irq_trig #(
    .CNT_W (CNT_W),
    .LVL0  (LVL0),
    .LVL1  (LVL1),
    .LVL2  (LVL2),
    .LVL3  (LVL3)
  ) u_trig (
    .sel_i     (trig_sel_i),
    .count_i   (rx_count_i),
    .reached_o (lvl_ok)
  );

  assign req[0] = ier_o[IE_RLS] & ((|lsr_err_i) | brk_o);
  assign req[1] = char_to_i;
  // blocked receive data falls through to lower sources
  assign req[2] = ier_o[IE_RXD] & data_ready_i & (~fifo_en_i | lvl_ok);
  assign req[3] = ier_o[IE_THR] & thr_pend_o;
  assign req[4] = ier_o[IE_MSR] & (|msr_delta_i);

  uart_irq_prio u_prio (
    .req_i  (req),
    .code_o (code)
  );

  assign iir_o = {{2{fifo_en_i}}, 2'b00, code};
  assign irq_o = ~code[0];
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ier_we_i,
  input logic [7:0] ier_wdata_i,
  input logic       iir_re_i,
  input logic       lsr_re_i,
  input logic       thre_i,
  input logic       thre_set_i,
  input logic       brk_det_i,
  input logic [2:0] lsr_err_i,
  input logic       char_to_i,
  input logic       data_ready_i,
  input logic [3:0] msr_delta_i,
  input logic [3:0] ier_o,
  input logic       thr_pend_o,
  input logic       brk_o,
  input logic [7:0] iir_o,
  input logic       irq_o
);
  AST_IIR_READ_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iir_re_i && !thre_set_i && !(ier_we_i && thre_i) |=> !thr_pend_o); // R6
  AST_IER_REARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ier_we_i && thre_i |=> thr_pend_o); // R7
  AST_IER_LOW_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ier_we_i |=> ier_o == $past(ier_wdata_i[3:0])); // R7
  AST_BRK_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lsr_re_i && brk_o && !brk_det_i |=> !brk_o); // R10
  AST_BRK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_det_i |=> brk_o); // R10
  AST_RLS_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ier_o[2] && (|lsr_err_i || brk_o) |-> iir_o[3:0] == 4'h6); // R1
  AST_CTO_NO_IER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_to_i && !ier_o[2] |-> iir_o[3:0] == 4'hC); // R5
  AST_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ier_o == 4'h0 && !char_to_i |-> iir_o[3:0] == 4'h1 && !irq_o); // R2
endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ier_we_i     (ier_we_i),
  .ier_wdata_i  (ier_wdata_i),
  .iir_re_i     (iir_re_i),
  .lsr_re_i     (lsr_re_i),
  .thre_i       (thre_i),
  .thre_set_i   (thre_set_i),
  .brk_det_i    (brk_det_i),
  .lsr_err_i    (lsr_err_i),
  .char_to_i    (char_to_i),
  .data_ready_i (data_ready_i),
  .msr_delta_i  (msr_delta_i),
  .ier_o        (ier_o),
  .thr_pend_o   (thr_pend_o),
  .brk_o        (brk_o),
  .iir_o        (iir_o),
  .irq_o        (irq_o)
);

// File: tb/tb_uart_irq_ident.sv
module tb_uart_irq_ident;
  localparam int unsigned CNT_W = 5;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic ier_we_i = 0, iir_re_i = 0, lsr_re_i = 0, thr_we_i = 0;
  logic thre_i = 0, thre_set_i = 0, brk_det_i = 0;
  logic [7:0] ier_wdata_i = '0;
  logic [2:0] lsr_err_i = '0;
  logic data_ready_i = 0, fifo_en_i = 0, char_to_i = 0;
  logic [CNT_W-1:0] rx_count_i = '0;
  logic [1:0] trig_sel_i = '0;
  logic [3:0] msr_delta_i = '0;
  logic [3:0] ier_o;
  logic thr_pend_o, brk_o, irq_o;
  logic [7:0] iir_o;

  int errs = 0, checks = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  uart_irq_ident dut (.*);

  // ier4 err3 dr1 fen1 cnt5 trig2 to1 thp1 msr4 exp8
  localparam int unsigned NV = 14;
  localparam logic [29:0] VEC [NV] = '{
    {4'hF, 3'b000, 1'b0, 1'b0, 5'd0,  2'd0, 1'b0, 1'b0, 4'h0, 8'h01},
    {4'hF, 3'b001, 1'b1, 1'b0, 5'd0,  2'd0, 1'b1, 1'b1, 4'h1, 8'h06},
    {4'hB, 3'b010, 1'b1, 1'b1, 5'd9,  2'd0, 1'b1, 1'b1, 4'h1, 8'hCC},
    {4'hF, 3'b000, 1'b1, 1'b0, 5'd0,  2'd3, 1'b0, 1'b1, 4'h1, 8'h04},
    {4'hF, 3'b000, 1'b1, 1'b1, 5'd3,  2'd1, 1'b0, 1'b1, 4'h1, 8'hC2},
    {4'hF, 3'b000, 1'b1, 1'b1, 5'd4,  2'd1, 1'b0, 1'b0, 4'h0, 8'hC4},
    {4'hF, 3'b000, 1'b1, 1'b1, 5'd13, 2'd3, 1'b0, 1'b0, 4'h1, 8'hC0},
    {4'hF, 3'b000, 1'b1, 1'b1, 5'd14, 2'd3, 1'b0, 1'b0, 4'h1, 8'hC4},
    {4'h0, 3'b111, 1'b1, 1'b0, 5'd0,  2'd0, 1'b0, 1'b1, 4'hF, 8'h01},
    {4'h8, 3'b000, 1'b0, 1'b0, 5'd0,  2'd0, 1'b0, 1'b0, 4'h8, 8'h00},
    {4'h2, 3'b000, 1'b1, 1'b0, 5'd0,  2'd0, 1'b0, 1'b1, 4'h2, 8'h02},
    {4'h1, 3'b000, 1'b1, 1'b1, 5'd1,  2'd0, 1'b0, 1'b0, 4'h0, 8'hC4},
    {4'h1, 3'b000, 1'b1, 1'b1, 5'd7,  2'd2, 1'b0, 1'b0, 4'h0, 8'hC1},
    {4'h4, 3'b100, 1'b0, 1'b0, 5'd0,  2'd0, 1'b0, 1'b0, 4'h0, 8'h06}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    #1;
    // R2 reset state
    chk("R2 ier", ier_o, 0);
    chk("R2 pend", thr_pend_o, 0);
    chk("R2 brk", brk_o, 0);
    chk("R2 iir", iir_o, 8'h01);
    chk("R11 irq", irq_o, 0);
    step();
    rst_ni = 1'b1;
    step();

    for (int v = 0; v < NV; v++) begin
      logic [29:0] e;
      e = VEC[v];
      lsr_err_i = e[25:23]; data_ready_i = e[22]; fifo_en_i = e[21];
      rx_count_i = e[20:16]; trig_sel_i = e[15:14]; char_to_i = e[13];
      msr_delta_i = e[11:8];
      ier_we_i = 1; ier_wdata_i = {4'h0, e[29:26]}; iir_re_i = 1; thre_i = 0;
      step();
      ier_we_i = 0; iir_re_i = 0; thre_set_i = e[12];
      step();
      thre_set_i = 0;
      #1;
      // R1 R3 R4 R5 R8 R9 R12 priority and gating
      chk($sformatf("R1 vec%0d iir", v), iir_o, e[7:0]);
      chk($sformatf("R11 vec%0d irq", v), irq_o, !e[0]);
    end

    // quiet inputs
    step();
    lsr_err_i = 0; data_ready_i = 0; fifo_en_i = 0; rx_count_i = 0;
    char_to_i = 0; msr_delta_i = 0;
    iir_re_i = 1;
    step();
    iir_re_i = 0;

    // R7 only low nibble stored, write with thre re-arms
    ier_we_i = 1; ier_wdata_i = 8'hF2; thre_i = 1;
    step();
    ier_we_i = 0; thre_i = 0; #1;
    chk("R7 ier low bits", ier_o, 4'h2);
    chk("R7 rearm", thr_pend_o, 1);
    chk("R6 thr code", iir_o, 8'h02);
    // R6 identification read clears pending
    step(); iir_re_i = 1;
    step(); iir_re_i = 0; #1;
    chk("R6 read clears", thr_pend_o, 0);
    chk("R6 idle after read", iir_o, 8'h01);
    // R6 holding write clears, set wins over clear
    step(); thre_set_i = 1; iir_re_i = 1;
    step(); thre_set_i = 0; iir_re_i = 0; #1;
    chk("R6 set wins", thr_pend_o, 1);
    step(); thr_we_i = 1;
    step(); thr_we_i = 0; #1;
    chk("R6 thr write clears", thr_pend_o, 0);
    // R7 ier write without thre does not arm
    step(); ier_we_i = 1; ier_wdata_i = 8'h06;
    step(); ier_we_i = 0; #1;
    chk("R7 no arm", thr_pend_o, 0);

    // R10 break flag
    step(); brk_det_i = 1;
    step(); brk_det_i = 0; #1;
    chk("R10 brk set", brk_o, 1);
    chk("R3 brk raises rls", iir_o, 8'h06);
    step(); lsr_re_i = 1; brk_det_i = 1;
    step(); lsr_re_i = 0; brk_det_i = 0; #1;
    chk("R10 set wins", brk_o, 1);
    step(); lsr_re_i = 1;
    step(); lsr_re_i = 0; #1;
    chk("R10 lsr read clears", brk_o, 0);
    chk("R3 rls gone", iir_o, 8'h01);

    // R11 same-cycle response, R9 fifo bits
    step(); char_to_i = 1; fifo_en_i = 1; #1;
    chk("R11 same cycle irq", irq_o, 1);
    chk("R9 fifo bits", iir_o, 8'hCC);
    char_to_i = 0; fifo_en_i = 0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule